// File: doc/BRIEF.md
# Custom Instruction Operand Collector

This block sits in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It builds the operand set for the execute stage. Ordinary instructions get the usual hazard bypass on their two register sources. Multi-input, single-output custom instructions can also take up to two more operands straight from the results of the two instructions issued just before them. The newest result comes from the EX/MEM register and the one before it from the MEM/WB register. Bits in the instruction select those two extra operands, so the compiler treats forwarding as an operand source it can name.

A custom instruction carries an 11-bit extension field in its low bits. The top three bits form a forward mask and the low eight bits pick the operation. When a source is bypassed, the register file read for it is switched off. The result positions of the predecessors must stay fixed. For that reason a late result (a cache miss or a busy multicycle unit) does not insert a bubble. It raises one freeze that holds every pipeline register and blocks the register-file write until the result is there.

Top module: `cust_operand_fwd`

## Requirements
- R1: While reset is asserted, and after reset until the first valid instruction is captured, exValid and exIllegal are 0.
- R2: An instruction whose bits [31:26] equal 6'b111010 is custom. It is captured with exIsCustom=1 and exCop=bits [7:0]. Operand A comes from source register bits [25:21] and operand B from bits [20:16], through the read ports or the bypass.
- R3: For a custom instruction, forward-mask bit 8 loads exOpC from the MEM/WB result and bit 9 loads exOpD from the EX/MEM result. An operand whose bit is clear is 0.
- R4: rfAddrA and rfAddrB carry the source fields. A read enable is 1 only for a valid instruction whose source is not bypassed.
- R5: A source field that is non-zero and matches a writing EX/MEM destination takes the EX/MEM result. Otherwise, if it matches a writing MEM/WB destination, it takes the MEM/WB result. Register 0 is never bypassed.
- R6: A custom instruction with mask bit 10 set, or with a mask bit that selects a slot that writes no register, is captured with exIllegal=1, and that operand is 0.
- R7: freeze is 1 in every cycle in which mulBusy or dMiss is 1. While it is 1, the execute-stage outputs do not change.
- R8: rfWeOut equals wbWeIn in cycles without freeze and is 0 while freeze is 1.
- R9: A non-custom instruction is captured with exIsCustom=0, exCop=0, exOpC=0, exOpD=0 and exIllegal=0, whatever its low bits hold.
- R10: At the first clock edge after mulBusy and dMiss fall, the instruction in decode is captured with the slot results present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idValid | input | 1 | Decode stage holds an instruction |
| idInstr | input | 32 | Instruction word in decode |
| rfDataA | input | 32 | Register file read port A data |
| rfDataB | input | 32 | Register file read port B data |
| exMemWrites | input | 1 | EX/MEM instruction writes a register |
| exMemDest | input | 5 | EX/MEM destination register |
| exMemResult | input | 32 | EX/MEM result |
| memWbWrites | input | 1 | MEM/WB instruction writes a register |
| memWbDest | input | 5 | MEM/WB destination register |
| memWbResult | input | 32 | MEM/WB result |
| mulBusy | input | 1 | Multicycle unit result not yet ready |
| dMiss | input | 1 | Data cache miss outstanding |
| wbWeIn | input | 1 | Writeback write request |
| rfAddrA | output | 5 | Read port A address |
| rfAddrB | output | 5 | Read port B address |
| rfReadEnA | output | 1 | Read port A enable |
| rfReadEnB | output | 1 | Read port B enable |
| freeze | output | 1 | Global pipeline freeze |
| rfWeOut | output | 1 | Gated register-file write enable |
| exValid | output | 1 | Execute stage holds an instruction |
| exIsCustom | output | 1 | Captured instruction is custom |
| exIllegal | output | 1 | Illegal forward selection |
| exCop | output | 8 | Custom operation code |
| exDest | output | 5 | Destination register |
| exOpA | output | 32 | Operand A |
| exOpB | output | 32 | Operand B |
| exOpC | output | 32 | Operand C (older predecessor) |
| exOpD | output | 32 | Operand D (newer predecessor) |

## Verification
The read addresses, read enables, freeze and gated write enable are combinational. They are due in the same cycle as the decode inputs, so the bench drives inputs on the falling edge and checks these outputs one nanosecond later. The execute-stage operands, flags and operation code come from a single register. They are checked at the falling edge that follows the next rising edge. During a freeze they are compared, on every frozen cycle, with the values recorded before the freeze started. After a release, the bench checks the capture one edge after mulBusy or dMiss drops. Each custom capture is also passed through a reference function in the bench, and the result is compared with the model applied to the expected operands.

// File: rtl/cust_fwd_pkg.sv
package cust_fwd_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int OPC_W  = 6;
  localparam int MASK_W = 3;
  localparam int COP_W  = 8;
  localparam int EXT_W  = MASK_W + COP_W;

  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } opSrc_e;

  typedef struct packed {
    logic   captureEn;
    logic   valid;
    logic   isCustom;
    logic   illegal;
    opSrc_e srcA;
    opSrc_e srcB;
    logic   takeC;
    logic   takeD;
  } ctrlStrobe_t;
endpackage

// File: rtl/cust_fwd_ctrl.sv
module cust_fwd_ctrl
  import cust_fwd_pkg::*;
#(
  parameter logic [OPC_W-1:0] CUST_OPCODE = 6'b111010
) (
  input  logic              idValid,
  input  logic [OPC_W-1:0]  opField,
  input  logic [REG_AW-1:0] rsField,
  input  logic [REG_AW-1:0] rtField,
  input  logic [MASK_W-1:0] maskField,
  input  logic              exMemWrites,
  input  logic [REG_AW-1:0] exMemDest,
  input  logic              memWbWrites,
  input  logic [REG_AW-1:0] memWbDest,
  input  logic              mulBusy,
  input  logic              dMiss,
  input  logic              wbWeIn,
  output logic              rfReadEnA,
  output logic              rfReadEnB,
  output logic              freeze,
  output logic              rfWeOut,
  output ctrlStrobe_t       strobe
);
  logic isCust;

  function automatic opSrc_e pickSrc(input logic [REG_AW-1:0] src,
                                     input logic emW, input logic [REG_AW-1:0] emD,
                                     input logic mwW, input logic [REG_AW-1:0] mwD);
    if (src != '0 && emW && emD == src)      return SRC_EXMEM;
    else if (src != '0 && mwW && mwD == src) return SRC_MEMWB;
    else                                     return SRC_RF;
  endfunction

  always_comb begin
    isCust = idValid && (opField == CUST_OPCODE);
    freeze = mulBusy | dMiss;
    rfWeOut = wbWeIn & ~freeze;

    strobe.captureEn = ~freeze;
    strobe.valid     = idValid;
    strobe.isCustom  = isCust;
    strobe.srcA      = pickSrc(rsField, exMemWrites, exMemDest, memWbWrites, memWbDest);
    strobe.srcB      = pickSrc(rtField, exMemWrites, exMemDest, memWbWrites, memWbDest);
    strobe.takeC     = isCust && maskField[0] && memWbWrites;
    strobe.takeD     = isCust && maskField[1] && exMemWrites;
    strobe.illegal   = isCust && (maskField[2]
                                  || (maskField[0] && !memWbWrites)
                                  || (maskField[1] && !exMemWrites));

    rfReadEnA = idValid && (strobe.srcA == SRC_RF);
    rfReadEnB = idValid && (strobe.srcB == SRC_RF);
  end
endmodule

// File: rtl/cust_fwd_datapath.sv
module cust_fwd_datapath
  import cust_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              freeze,
  input  logic [REG_AW-1:0] rdField,
  input  logic [COP_W-1:0]  copField,
  input  logic [XLEN-1:0]   rfDataA,
  input  logic [XLEN-1:0]   rfDataB,
  input  logic [XLEN-1:0]   exMemResult,
  input  logic [XLEN-1:0]   memWbResult,
  output logic              exValid,
  output logic              exIsCustom,
  output logic              exIllegal,
  output logic [COP_W-1:0]  exCop,
  output logic [REG_AW-1:0] exDest,
  output logic [XLEN-1:0]   exOpA,
  output logic [XLEN-1:0]   exOpB,
  output logic [XLEN-1:0]   exOpC,
  output logic [XLEN-1:0]   exOpD
);
  logic [XLEN-1:0] nxtA, nxtB, nxtC, nxtD;

  function automatic logic [XLEN-1:0] srcMux(input opSrc_e sel,
                                             input logic [XLEN-1:0] rf,
                                             input logic [XLEN-1:0] em,
                                             input logic [XLEN-1:0] mw);
    case (sel)
      SRC_EXMEM: return em;
      SRC_MEMWB: return mw;
      default:   return rf;
    endcase
  endfunction

  always_comb begin
    nxtA = srcMux(strobe.srcA, rfDataA, exMemResult, memWbResult);
    nxtB = srcMux(strobe.srcB, rfDataB, exMemResult, memWbResult);
    nxtC = strobe.takeC ? memWbResult : '0;
    nxtD = strobe.takeD ? exMemResult : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exValid    <= 1'b0;
      exIsCustom <= 1'b0;
      exIllegal  <= 1'b0;
      exCop      <= '0;
      exDest     <= '0;
      exOpA      <= '0;
      exOpB      <= '0;
      exOpC      <= '0;
      exOpD      <= '0;
    end else if (strobe.captureEn) begin
      exValid    <= strobe.valid;
      exIsCustom <= strobe.isCustom;
      exIllegal  <= strobe.illegal;
      exCop      <= strobe.isCustom ? copField : '0;
      exDest     <= strobe.valid ? rdField : '0;
      exOpA      <= strobe.valid ? nxtA : '0;
      exOpB      <= strobe.valid ? nxtB : '0;
      exOpC      <= nxtC;
      exOpD      <= nxtD;
    end
  end

  // R7: a frozen cycle leaves the execute-stage register untouched
  a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> ($stable(exOpA) && $stable(exOpB) && $stable(exOpC)
                && $stable(exOpD) && $stable(exValid) && $stable(exCop)));

  // R10: an unfrozen valid decode is captured at the next edge
  a_r10_capture: assert property (@(posedge clk) disable iff (!rstN)
    (!freeze && strobe.valid) |=> exValid);

  // R9: plain instructions never carry extra operands or flags
  a_r9_plain_clean: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && !exIsCustom) |-> (exOpC == '0 && exOpD == '0 && !exIllegal && exCop == '0));

  // R1: nothing valid right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !exValid |-> !exIllegal);
endmodule

// File: rtl/cust_operand_fwd.sv
module cust_operand_fwd
  import cust_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idValid,
  input  logic [31:0]       idInstr,
  input  logic [XLEN-1:0]   rfDataA,
  input  logic [XLEN-1:0]   rfDataB,
  input  logic              exMemWrites,
  input  logic [REG_AW-1:0] exMemDest,
  input  logic [XLEN-1:0]   exMemResult,
  input  logic              memWbWrites,
  input  logic [REG_AW-1:0] memWbDest,
  input  logic [XLEN-1:0]   memWbResult,
  input  logic              mulBusy,
  input  logic              dMiss,
  input  logic              wbWeIn,
  output logic [REG_AW-1:0] rfAddrA,
  output logic [REG_AW-1:0] rfAddrB,
  output logic              rfReadEnA,
  output logic              rfReadEnB,
  output logic              freeze,
  output logic              rfWeOut,
  output logic              exValid,
  output logic              exIsCustom,
  output logic              exIllegal,
  output logic [COP_W-1:0]  exCop,
  output logic [REG_AW-1:0] exDest,
  output logic [XLEN-1:0]   exOpA,
  output logic [XLEN-1:0]   exOpB,
  output logic [XLEN-1:0]   exOpC,
  output logic [XLEN-1:0]   exOpD
);
  logic [OPC_W-1:0]  opField;
  logic [REG_AW-1:0] rsField, rtField, rdField;
  logic [MASK_W-1:0] maskField;
  logic [COP_W-1:0]  copField;
  ctrlStrobe_t       strobe;

  assign opField   = idInstr[31:26];
  assign rsField   = idInstr[25:21];
  assign rtField   = idInstr[20:16];
  assign rdField   = idInstr[15:11];
  assign maskField = idInstr[EXT_W-1:COP_W];
  assign copField  = idInstr[COP_W-1:0];
  assign rfAddrA   = rsField;
  assign rfAddrB   = rtField;

  cust_fwd_ctrl u_ctrl (
    .idValid(idValid), .opField(opField), .rsField(rsField), .rtField(rtField),
    .maskField(maskField), .exMemWrites(exMemWrites), .exMemDest(exMemDest),
    .memWbWrites(memWbWrites), .memWbDest(memWbDest), .mulBusy(mulBusy),
    .dMiss(dMiss), .wbWeIn(wbWeIn), .rfReadEnA(rfReadEnA), .rfReadEnB(rfReadEnB),
    .freeze(freeze), .rfWeOut(rfWeOut), .strobe(strobe)
  );

  cust_fwd_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .freeze(freeze), .rdField(rdField),
    .copField(copField), .rfDataA(rfDataA), .rfDataB(rfDataB),
    .exMemResult(exMemResult), .memWbResult(memWbResult), .exValid(exValid),
    .exIsCustom(exIsCustom), .exIllegal(exIllegal), .exCop(exCop), .exDest(exDest),
    .exOpA(exOpA), .exOpB(exOpB), .exOpC(exOpC), .exOpD(exOpD)
  );
endmodule

// File: tb/sim_cust_operand_fwd.sv
`timescale 1ns/1ps
module sim_cust_operand_fwd;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, idValid, exMemWrites, memWbWrites, mulBusy, dMiss, wbWeIn;
  logic [31:0] idInstr, rfDataA, rfDataB, exMemResult, memWbResult;
  logic [4:0] exMemDest, memWbDest, rfAddrA, rfAddrB, exDest;
  logic rfReadEnA, rfReadEnB, freeze, rfWeOut, exValid, exIsCustom, exIllegal;
  logic [7:0] exCop;
  logic [31:0] exOpA, exOpB, exOpC, exOpD;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  cust_operand_fwd u0 (.*);

  localparam logic [5:0] OP_CUST = 6'b111010;
  localparam logic [5:0] OP_ADD  = 6'b000000;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [4:0] rd,
                                     input logic [2:0] mask, input logic [7:0] cop);
    return {op, rs, rt, rd, mask, cop};
  endfunction

  // reference custom function unit
  function automatic logic [31:0] cfu(input logic [7:0] cop, input logic [31:0] a,
                                      input logic [31:0] b, input logic [31:0] c,
                                      input logic [31:0] d);
    return ((a + b) ^ (c - d)) + {24'd0, cop};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    idValid = 0; idInstr = 0; rfDataA = 0; rfDataB = 0;
    exMemWrites = 0; exMemDest = 0; exMemResult = 0;
    memWbWrites = 0; memWbDest = 0; memWbResult = 0;
    mulBusy = 0; dMiss = 0; wbWeIn = 0;
  endtask

  task automatic slots(input logic emW, input logic [4:0] emD, input logic [31:0] emR,
                       input logic mwW, input logic [4:0] mwD, input logic [31:0] mwR);
    exMemWrites = emW; exMemDest = emD; exMemResult = emR;
    memWbWrites = mwW; memWbDest = mwD; memWbResult = mwR;
  endtask

  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    idValid = 1; idInstr = ins; rfDataA = a; rfDataB = b;
  endtask

  task automatic testReset();
    chk("R1 exValid in reset", {31'd0, exValid}, 32'd0);
    chk("R1 exIllegal in reset", {31'd0, exIllegal}, 32'd0);
    rstN = 1;
    @(negedge clk);
    chk("R1 exValid after reset", {31'd0, exValid}, 32'd0);
  endtask

  task automatic testPlain();
    slots(1, 5'd20, 32'hDEAD0001, 1, 5'd21, 32'hDEAD0002);
    issue(mk(OP_ADD, 5'd3, 5'd4, 5'd9, 3'b111, 8'hFF), 32'h11, 32'h22);
    #1;
    chk("R4 rfAddrA", {27'd0, rfAddrA}, 32'd3);
    chk("R4 read enables plain", {30'd0, rfReadEnA, rfReadEnB}, 32'd3);
    @(negedge clk);
    chk("R9 plain opA", exOpA, 32'h11);
    chk("R9 plain opB", exOpB, 32'h22);
    chk("R9 plain C/D zero", exOpC | exOpD, 32'd0);
    chk("R9 plain flags", {29'd0, exIsCustom, exIllegal, exValid}, 32'd1);
    chk("R9 plain cop", {24'd0, exCop}, 32'd0);
  endtask

  task automatic testBypass();
    slots(1, 5'd6, 32'hAAAA0006, 1, 5'd6, 32'hBBBB0006);
    memWbDest = 5'd6;
    issue(mk(OP_ADD, 5'd6, 5'd0, 5'd2, 3'b000, 8'h00), 32'h1, 32'h2);
    #1;
    chk("R4 read A off, B on", {30'd0, rfReadEnA, rfReadEnB}, 32'd1);
    @(negedge clk);
    chk("R5 EX/MEM wins", exOpA, 32'hAAAA0006);
    chk("R5 reg0 not bypassed", exOpB, 32'h2);
    slots(1, 5'd0, 32'hCCCC0000, 1, 5'd7, 32'hDDDD0007);
    issue(mk(OP_ADD, 5'd0, 5'd7, 5'd2, 3'b000, 8'h00), 32'h5, 32'h6);
    #1;
    chk("R4 read A on, B off", {30'd0, rfReadEnA, rfReadEnB}, 32'd2);
    @(negedge clk);
    chk("R5 dest0 ignored", exOpA, 32'h5);
    chk("R5 MEM/WB used", exOpB, 32'hDDDD0007);
  endtask

  task automatic testCustomBackToBack();
    logic [31:0] r1;
    slots(1, 5'd10, 32'h00000100, 1, 5'd11, 32'h00000200);
    issue(mk(OP_CUST, 5'd1, 5'd2, 5'd12, 3'b011, 8'h5A), 32'h1000, 32'h2000);
    @(negedge clk);
    chk("R2 custom flag", {31'd0, exIsCustom}, 32'd1);
    chk("R2 cop", {24'd0, exCop}, 32'h5A);
    chk("R3 C from MEM/WB", exOpC, 32'h200);
    chk("R3 D from EX/MEM", exOpD, 32'h100);
    r1 = cfu(8'h5A, 32'h1000, 32'h2000, 32'h200, 32'h100);
    chk("R3 model result 1", cfu(exCop, exOpA, exOpB, exOpC, exOpD), r1);
    // next custom uses the previous custom's result as D only
    slots(1, 5'd12, r1, 1, 5'd10, 32'h00000100);
    issue(mk(OP_CUST, 5'd3, 5'd4, 5'd13, 3'b010, 8'h03), 32'h7, 32'h9);
    @(negedge clk);
    chk("R3 D is previous custom", exOpD, r1);
    chk("R3 C unselected zero", exOpC, 32'd0);
    chk("R3 model result 2", cfu(exCop, exOpA, exOpB, exOpC, exOpD),
        cfu(8'h03, 32'h7, 32'h9, 32'd0, r1));
  endtask

  task automatic testIllegal();
    slots(1, 5'd10, 32'h55, 0, 5'd11, 32'h66);
    issue(mk(OP_CUST, 5'd1, 5'd2, 5'd3, 3'b001, 8'h01), 32'h1, 32'h2);
    @(negedge clk);
    chk("R6 illegal non-writing slot", {31'd0, exIllegal}, 32'd1);
    chk("R6 illegal operand zero", exOpC, 32'd0);
    slots(1, 5'd10, 32'h55, 1, 5'd11, 32'h66);
    issue(mk(OP_CUST, 5'd1, 5'd2, 5'd3, 3'b100, 8'h01), 32'h1, 32'h2);
    @(negedge clk);
    chk("R6 reserved mask bit", {31'd0, exIllegal}, 32'd1);
    issue(mk(OP_CUST, 5'd1, 5'd2, 5'd3, 3'b011, 8'h01), 32'h1, 32'h2);
    @(negedge clk);
    chk("R6 legal mask", {31'd0, exIllegal}, 32'd0);
  endtask

  task automatic testLate(input bit useMiss, input logic [2:0] mask, input string tag);
    logic [31:0] holdA, holdD;
    issue(mk(OP_ADD, 5'd1, 5'd2, 5'd3, 3'b000, 8'h00), 32'hABCD, 32'h1234);
    slots(0, 5'd0, 0, 0, 5'd0, 0);
    @(negedge clk);
    holdA = exOpA; holdD = exOpD;
    slots(1, 5'd8, 32'hBAD0BAD0, 1, 5'd9, 32'hBAD1BAD1);
    issue(mk(OP_CUST, 5'd4, 5'd5, 5'd6, mask, 8'h21), 32'h40, 32'h50);
    wbWeIn = 1;
    if (useMiss) dMiss = 1; else mulBusy = 1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk({"R7 freeze high ", tag}, {31'd0, freeze}, 32'd1);
      chk({"R8 write blocked ", tag}, {31'd0, rfWeOut}, 32'd0);
      @(negedge clk);
      chk({"R7 opA held ", tag}, exOpA, holdA);
      chk({"R7 opD held ", tag}, exOpD, holdD);
    end
    dMiss = 0; mulBusy = 0;
    if (useMiss) exMemResult = 32'h0000F00D; else memWbResult = 32'h0000BEEF;
    #1;
    chk({"R8 write passes ", tag}, {31'd0, rfWeOut}, 32'd1);
    @(negedge clk);
    if (useMiss) chk({"R10 load data in D ", tag}, exOpD, 32'h0000F00D);
    else         chk({"R10 product in C ", tag}, exOpC, 32'h0000BEEF);
    chk({"R10 model ", tag}, cfu(exCop, exOpA, exOpB, exOpC, exOpD),
        useMiss ? cfu(8'h21, 32'h40, 32'h50, 32'd0, 32'h0000F00D)
                : cfu(8'h21, 32'h40, 32'h50, 32'h0000BEEF, 32'd0));
    wbWeIn = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    rstN = 0;
    quiet();
    repeat (3) @(negedge clk);
    testReset();
    testPlain();
    testBypass();
    testCustomBackToBack();
    testIllegal();
    testLate(1'b1, 3'b010, "miss");
    testLate(1'b0, 3'b001, "mul");
    quiet();
    @(negedge clk);
    finished = 1;
    summary();
  end
endmodule